// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It reads a two-level page table that sits in a word-addressed memory. A request carries the logical address and whether the access is a read or a write. The walker then makes up to two table reads on a single-outstanding memory port. It checks presence and write permission, and it can write the second-level entry back with its usage bits updated. It returns either a physical address or a fault code on a valid/ready response channel.

Pages are 8 KB. The 13-bit page offset is never translated. The 19-bit page number is split in two parts: the upper part indexes the first-level table, and the lower part indexes a second-level table. A base register gives the location of the first-level table, and only privileged code may change it. One walk is in flight at a time.

Top module: `page_walker`

## Requirements
- R1: A successful walk returns `rsp_paddr_o` = {second-level entry bits 31:13 (frame number), logical address bits 12:0}, with `rsp_fault_o` = 2'b00.
- R2: The first-level read goes to word address {base register, logical bits 31:22}. If bit 0 of the first-level entry is 1, the second-level read goes to word address {first-level entry bits 31:9, logical bits 21:13}.
- R3: If the first-level entry has bit 0 = 0, the walk ends with `rsp_fault_o` = 2'b01 (not present) after exactly one memory read and no write.
- R4: If the second-level entry has bit 0 (valid) = 0, the walk ends with fault 2'b01. All other fields of that entry are ignored and nothing is written back.
- R5: A write access to a second-level entry whose bit 3 (write permit) is 0 ends with fault 2'b10 (protection) and no write-back. A read access to such an entry succeeds.
- R6: On success the walker writes the entry back with bit 1 (referenced) set. A write access also sets bit 2 (dirty). No write is made when those bits are already set. The response follows the write-back.
- R7: The base register resets to 0. It loads `base_wdata_i` (the first-level table address divided by 1024 words) on `base_we_i` only while `priv_i` is 1. Otherwise the write is ignored.
- R8: `req_ready_o` is 1 only when no walk is in flight. `busy_o` is 1 from the cycle after acceptance until the response handshake. The response holds its valid signal, address and fault stable until `rsp_ready_i`.
- R9: `mem_req_o` stays high with a stable address and write data until the cycle in which `mem_ack_i` is 1. Read data is taken in that cycle.
- R10: On any fault `rsp_paddr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | Privileged mode; enables base register writes |
| base_we_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 22 | First-level table word address divided by 1024 |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 32 | Logical address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | 00 ok, 01 not present, 10 protection |
| busy_o | output | 1 | Walk in flight |
| mem_req_o | output | 1 | Table memory request |
| mem_we_o | output | 1 | Request is a write-back |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |

## Verification
The bench targets these cases:
- A first-level miss. A walker that read the second level anyway would show two reads instead of one.
- An invalid second-level entry whose frame and flag bits are nonzero. Using those bits would give a wrong address or a stray write-back.
- A write to a read-only page. A walker that ignored the permit bit would return an address and set the dirty bit.
- Entries whose referenced and dirty bits are already set. A walker that always wrote back would show an extra write.
- A base register write without privilege. Accepting it would move the first-level table.
- A stalled response. Dropping or changing the response before the handshake would show at the ports.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 13;
  localparam int L1_W  = 10;
  localparam int DW    = 32;
  localparam int AW    = 32;

  // second-level entry flag positions
  localparam int PTE_VALID = 0;
  localparam int PTE_REF   = 1;
  localparam int PTE_DIRTY = 2;
  localparam int PTE_WR    = 3;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;
endpackage

// File: rtl/pgw_base_reg.sv
module pgw_base_reg #(
  parameter int BW = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          priv_i,
  input  logic          we_i,
  input  logic [BW-1:0] data_i,
  output logic [BW-1:0] base_o
);
  logic [BW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              base_q <= '0;
    else if (we_i && priv_i)  base_q <= data_i;
  end

  assign base_o = base_q;

  // R7
  unpriv_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> $stable(base_o));

  // R7
  priv_write_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && priv_i) |=> (base_o == $past(data_i)));
endmodule

// File: rtl/pgw_pte_eval.sv
module pgw_pte_eval
  import pgw_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFF_W = 13
) (
  input  logic [DW-1:0]    pte_i,
  input  logic             write_i,
  input  logic [OFF_W-1:0] off_i,
  output fault_e           fault_o,
  output logic [DW-1:0]    paddr_o,
  output logic             upd_o,
  output logic [DW-1:0]    pte_upd_o
);
  logic [DW-1:0] set_mask;

  always_comb begin
    set_mask            = '0;
    set_mask[PTE_REF]   = 1'b1;
    set_mask[PTE_DIRTY] = write_i;
    pte_upd_o           = pte_i | set_mask;
    upd_o               = 1'b0;
    paddr_o             = '0;
    if (!pte_i[PTE_VALID]) begin
      fault_o = FLT_ABSENT;
    end else if (write_i && !pte_i[PTE_WR]) begin
      fault_o = FLT_PROT;
    end else begin
      fault_o = FLT_NONE;
      paddr_o = {pte_i[DW-1:OFF_W], off_i};
      upd_o   = (pte_upd_o != pte_i);
    end
  end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 13,
  parameter int L1_W  = 10,
  parameter int DW    = 32,
  parameter int AW    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-L1_W-1:0] base_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_vaddr_i,
  input  logic               req_write_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [DW-1:0]      rsp_paddr_o,
  output logic [1:0]         rsp_fault_o,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [DW-1:0]      mem_rdata_i
);
  localparam int L2_W = VA_W - OFF_W - L1_W;
  localparam int LO_W = VA_W - L1_W;

  typedef enum logic [2:0] {ST_IDLE, ST_L1, ST_L2, ST_WB, ST_RSP} st_e;

  st_e            st_q;
  logic [LO_W-1:0] va_q;
  logic           wr_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wb_q;
  logic [DW-1:0]  pa_q;
  fault_e         flt_q;

  fault_e         ev_fault;
  logic [DW-1:0]  ev_paddr;
  logic           ev_upd;
  logic [DW-1:0]  ev_pte;

  pgw_pte_eval #(.DW(DW), .OFF_W(OFF_W)) u_eval (
    .pte_i     (mem_rdata_i),
    .write_i   (wr_q),
    .off_i     (va_q[OFF_W-1:0]),
    .fault_o   (ev_fault),
    .paddr_o   (ev_paddr),
    .upd_o     (ev_upd),
    .pte_upd_o (ev_pte)
  );

  logic done;
  assign done = mem_req_o && mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wb_q   <= '0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i[LO_W-1:0];
          wr_q   <= req_write_i;
          addr_q <= {base_i, req_vaddr_i[VA_W-1 -: L1_W]};
          st_q   <= ST_L1;
        end
        ST_L1: if (done) begin
          if (!mem_rdata_i[PTE_VALID]) begin
            flt_q <= FLT_ABSENT;
            pa_q  <= '0;
            st_q  <= ST_RSP;
          end else begin
            addr_q <= {mem_rdata_i[AW-1:L2_W], va_q[OFF_W +: L2_W]};
            st_q   <= ST_L2;
          end
        end
        ST_L2: if (done) begin
          flt_q <= ev_fault;
          pa_q  <= ev_paddr;
          wb_q  <= ev_pte;
          st_q  <= ev_upd ? ST_WB : ST_RSP;
        end
        ST_WB:  if (done) st_q <= ST_RSP;
        ST_RSP: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RSP);
  assign rsp_paddr_o = pa_q;
  assign rsp_fault_o = flt_q;
  assign mem_req_o   = (st_q == ST_L1) || (st_q == ST_L2) || (st_q == ST_WB);
  assign mem_we_o    = (st_q == ST_WB);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wb_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_wdata_o)));

  // R8
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && !req_ready_o));

  // R3
  l1_miss_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_L1 && mem_ack_i && !mem_rdata_i[PTE_VALID]) |=> (!mem_req_o && rsp_valid_o
                                                                 && rsp_fault_o == FLT_ABSENT));

  // R10
  fault_zero_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> (rsp_paddr_o == '0));

  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE) |-> (rsp_paddr_o[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R6
  wb_ref_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o[PTE_REF] && mem_wdata_o[PTE_VALID]
                                 && (mem_wdata_o[PTE_DIRTY] || !wr_q)));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pgw_pkg::*;
#(
  parameter int VA_W  = pgw_pkg::VA_W,
  parameter int OFF_W = pgw_pkg::OFF_W,
  parameter int L1_W  = pgw_pkg::L1_W,
  parameter int DW    = pgw_pkg::DW,
  parameter int AW    = pgw_pkg::AW,
  localparam int BW   = AW - L1_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            priv_i,
  input  logic            base_we_i,
  input  logic [BW-1:0]   base_wdata_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic            req_write_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [DW-1:0]   rsp_paddr_o,
  output logic [1:0]      rsp_fault_o,
  output logic            busy_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i
);
  logic [BW-1:0] base;

  pgw_base_reg #(.BW(BW)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .priv_i (priv_i),
    .we_i   (base_we_i),
    .data_i (base_wdata_i),
    .base_o (base)
  );

  pgw_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .L1_W(L1_W), .DW(DW), .AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_i      (base),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_vaddr_i (req_vaddr_i),
    .req_write_i (req_write_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_fault_o (rsp_fault_o),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i)
  );
endmodule

// File: tb/sim_page_walker.sv
`timescale 1ns/1ps
module sim_page_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv = 1'b0, base_we = 1'b0;
  logic [21:0] base_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, busy, mem_req, mem_we;
  logic [31:0] rsp_paddr, mem_addr, mem_wdata;
  logic [1:0]  rsp_fault;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int n_rd = 0, n_wr = 0;

  always #2.5 clk = ~clk;

  page_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .base_we_i(base_we),
    .base_wdata_i(base_wdata), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault),
    .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // table memory model: 4096 words, ack two cycles after a request appears
  logic [31:0] mem [0:4095];
  int lat = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 32'h0;
      mem[0]    <= 32'h0000_0401;  // L1[0] -> L2 table at 1024
      mem[1]    <= 32'h0000_0601;  // L1[1] -> L2 table at 1536
      mem[1024] <= 32'h0000_A009;  // frame 5, valid, writable
      mem[1025] <= 32'hFFFF_E003;  // frame 7FFFF, valid, referenced, read-only
      mem[1026] <= 32'h0002_E00E;  // invalid, junk in other fields
      mem[1541] <= 32'h2468_A00F;  // frame 12345, all flags set
      mem[2048] <= 32'h0000_0601;  // alternate L1[0] -> 1536
      mem_ack <= 1'b0;
      lat <= 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && mem_ack) begin
        if (mem_we) n_wr <= n_wr + 1; else n_rd <= n_rd + 1;
      end
      if (mem_req && !mem_ack) begin
        if (lat == 2) begin
          mem_ack   <= 1'b1;
          mem_rdata <= mem[mem_addr[11:0]];
          if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
          lat <= 0;
        end else lat <= lat + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, output logic [31:0] pa,
                      output logic [1:0] flt, output int rd, output int wrc);
    int r0, w0;
    r0 = n_rd; w0 = n_wr;
    @(negedge clk); req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    pa = rsp_paddr; flt = rsp_fault;
    @(negedge clk);
    rd = n_rd - r0; wrc = n_wr - w0;
  endtask

  typedef struct packed {
    logic [31:0] va; logic wr; logic [31:0] pa; logic [1:0] flt;
    logic [3:0] nrd; logic [3:0] nwr; logic [11:0] idx; logic [31:0] ent;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0123, 1'b0, 32'h0000_A123, 2'b00, 4'd2, 4'd1, 12'd1024, 32'h0000_A00B}, // R1 R2 R6 ref set
    '{32'h0000_1FFF, 1'b1, 32'h0000_BFFF, 2'b00, 4'd2, 4'd1, 12'd1024, 32'h0000_A00F}, // R6 dirty set
    '{32'h0000_0000, 1'b0, 32'h0000_A000, 2'b00, 4'd2, 4'd0, 12'd1024, 32'h0000_A00F}, // R6 no write
    '{32'h0000_20FF, 1'b0, 32'hFFFF_E0FF, 2'b00, 4'd2, 4'd0, 12'd1025, 32'hFFFF_E003}, // R5 read ok
    '{32'h0000_2000, 1'b1, 32'h0000_0000, 2'b10, 4'd2, 4'd0, 12'd1025, 32'hFFFF_E003}, // R5 R10
    '{32'h0000_4010, 1'b0, 32'h0000_0000, 2'b01, 4'd2, 4'd0, 12'd1026, 32'h0002_E00E}, // R4
    '{32'h0080_0000, 1'b0, 32'h0000_0000, 2'b01, 4'd1, 4'd0, 12'd2,    32'h0000_0000}, // R3
    '{32'h0040_BABC, 1'b1, 32'h2468_BABC, 2'b00, 4'd2, 4'd0, 12'd1541, 32'h2468_A00F}, // R2 second table
    '{32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 2'b01, 4'd1, 4'd0, 12'd1023, 32'h0000_0000}  // R3 top index
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] pa, pa_hold;
    logic [1:0]  flt;
    int rd, wrc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 reset busy", {31'b0, busy}, 32'd0);
    chk("R8 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R8 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R9 reset mem_req", {31'b0, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      walk(VECS[i].va, VECS[i].wr, pa, flt, rd, wrc);
      chk($sformatf("R1 vec%0d paddr", i), pa, VECS[i].pa);
      chk($sformatf("R3 R4 R5 vec%0d fault", i), {30'b0, flt}, {30'b0, VECS[i].flt});
      chk($sformatf("R2 R3 vec%0d reads", i), rd, {28'b0, VECS[i].nrd});
      chk($sformatf("R6 vec%0d writes", i), wrc, {28'b0, VECS[i].nwr});
      chk($sformatf("R6 vec%0d entry", i), mem[VECS[i].idx], VECS[i].ent);
    end

    // R8: busy during walk, response held while rsp_ready low
    rsp_ready = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_vaddr = 32'h0000_0123; req_write = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    chk("R8 busy in walk", {31'b0, busy}, 32'd1);
    chk("R8 not ready in walk", {31'b0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    pa_hold = rsp_paddr;
    repeat (3) @(negedge clk);
    chk("R8 rsp held valid", {31'b0, rsp_valid}, 32'd1);
    chk("R8 rsp held paddr", rsp_paddr, pa_hold);
    chk("R1 held paddr value", pa_hold, 32'h0000_A123);
    chk("R8 busy while held", {31'b0, busy}, 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 rsp released", {31'b0, rsp_valid}, 32'd0);
    chk("R8 idle after rsp", {31'b0, busy}, 32'd0);

    // R7: unprivileged base write ignored
    priv = 1'b0; base_we = 1'b1; base_wdata = 22'd2;
    @(negedge clk); base_we = 1'b0;
    walk(32'h0000_A456, 1'b0, pa, flt, rd, wrc);
    chk("R7 unpriv write ignored", {30'b0, flt}, 32'd1);  // base 0: L1[0] -> 1024, p2=5 invalid
    // R7: privileged base write takes effect
    priv = 1'b1; base_we = 1'b1; base_wdata = 22'd2;      // L1 table at word 2048
    @(negedge clk); base_we = 1'b0; priv = 1'b0;
    walk(32'h0000_A456, 1'b0, pa, flt, rd, wrc);
    chk("R7 priv write paddr", pa, 32'h2468_A456);
    chk("R7 priv write fault", {30'b0, flt}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule